// File: doc/BRIEF.md
# Port Input-Change Interrupt Detector

This block watches a small group of port input pins and raises a sticky change flag when the pins differ from what software last read. Each port read is marked by a read strobe. The rising edge of the strobe loads the pins into a "current" latch. The falling edge loads them into a "previous" latch. The two latches are compared bit by bit, and any disagreement on a pin configured as an input sets the flag.

The comparison is therefore made against the last read, not against the previous clock cycle. A pin that moves while the strobe is high leaves the two latches disagreeing. That disagreement lasts until the next read brings them back into line. While it lasts, it keeps setting the flag even after software clears it. An enable bit gates the flag onto the interrupt output. The detector reports that some pin changed, not which one.

The read strobe is brought into the clock domain through a configurable synchroniser chain. Its two edges become single-cycle load pulses. Pins, direction bits, enable and clear are taken as synchronous to the clock.

Top module: `chg_irq_det`

## Requirements
- R1: After reset the change flag and the interrupt output are 0, and both latches hold all zeros, so pins held at 0 never set the flag.
- R2: The current latch loads all pin values only on the clock edge after a synchronised rising edge of the read strobe. With the default two synchroniser stages, this is the third clock edge after the strobe goes high. Pin changes with no read strobe activity never set the flag.
- R3: The previous latch loads all pin values only on the clock edge after a synchronised falling edge of the read strobe. With the default settings, this is the third clock edge after the strobe goes low.
- R4: The combined mismatch is the OR over pins of (current bit XOR previous bit), each term counted only for input pins. On any clock edge where the combined mismatch is 1, the flag becomes 1.
- R5: A pin whose direction bit is 0 (output mode) takes no part in change detection. Direction bit 1 selects input mode.
- R6: If an input pin changes while the read strobe is high, the flag becomes 1 after the strobe falls and stays mismatched.
- R7: The flag holds its value with no mismatch and no clear. A clear strobe with no mismatch present makes the flag 0 on that edge.
- R8: A clear strobe in a cycle with a mismatch present has no effect: the flag stays 1. After a read with stable pins re-aligns the latches, a clear succeeds.
- R9: The interrupt output equals (flag AND enable) as registered one clock earlier.
- R10: A complete read with pins held stable and latches equal never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| pin_i | input | NPINS | Port pin levels |
| dir_in_i | input | NPINS | Per-pin direction, 1 = input (watched), 0 = output |
| rd_strobe_i | input | 1 | Port read strobe, asynchronous level |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clear strobe for the change flag |
| chg_flag_o | output | 1 | Sticky change flag |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A clear of the flag and a set of the flag by a standing mismatch can fall in the same cycle. This happens when software clears the flag before the next read has re-aligned the latches. It is provoked on purpose by moving a pin while the strobe is high and then pulsing the clear. Random clear pulses also land during mismatched intervals. The expected result is that the flag stays 1 on that edge and drops only on a clear issued after a stable read. The bench judges this against its own cycle model and directed checks.

// File: rtl/chgdet_pkg.sv
package chgdet_pkg;

   typedef struct packed {
      logic rise;
      logic fall;
   } strobe_edge_t;

   localparam int unsigned MAX_PINS = 32;
   localparam int unsigned MAX_SYNC = 4;

endpackage

// File: rtl/chgdet_strobe_edge.sv
module chgdet_strobe_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                      clk_i,
   input  logic                      rst_n_i,
   input  logic                      strobe_i,
   output chgdet_pkg::strobe_edge_t  edge_o
);

   logic lvl;
   logic lvl_prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl = strobe_i;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= strobe_i;
               for (int k = 1; k < int'(SYNC_STAGES); k++) begin
                  chain_q[k] <= chain_q[k-1];
               end
            end
         end
         assign lvl = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) lvl_prev_q <= 1'b0;
      else          lvl_prev_q <= lvl;
   end

   assign edge_o.rise = lvl & ~lvl_prev_q;
   assign edge_o.fall = ~lvl & lvl_prev_q;

endmodule

// File: rtl/chgdet_latch_pair.sv
module chgdet_latch_pair #(
   parameter int unsigned NPINS = 4
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [NPINS-1:0] pin_i,
   input  logic [NPINS-1:0] dir_in_i,
   input  logic             load_cur_i,
   input  logic             load_prev_i,
   output logic [NPINS-1:0] cur_o,
   output logic [NPINS-1:0] prev_o,
   output logic             mis_o
);

   logic [NPINS-1:0] cur_q;
   logic [NPINS-1:0] prev_q;
   logic [NPINS-1:0] mis_bit;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cur_q  <= '0;
         prev_q <= '0;
      end else begin
         if (load_cur_i)  cur_q  <= pin_i;
         if (load_prev_i) prev_q <= pin_i;
      end
   end

   generate
      for (genvar i = 0; i < int'(NPINS); i++) begin : g_bit
         assign mis_bit[i] = dir_in_i[i] & (cur_q[i] ^ prev_q[i]);
      end
   endgenerate

   assign mis_o  = |mis_bit;
   assign cur_o  = cur_q;
   assign prev_o = prev_q;

endmodule

// File: rtl/chgdet_flag.sv
module chgdet_flag (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic set_i,
   input  logic clr_i,
   input  logic en_i,
   output logic flag_o,
   output logic irq_o
);

   logic flag_q;
   logic irq_q;
   logic flag_d;

   always_comb begin
      flag_d = flag_q;
      if (set_i)      flag_d = 1'b1;
      else if (clr_i) flag_d = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         flag_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         flag_q <= flag_d;
         irq_q  <= flag_q & en_i;
      end
   end

   assign flag_o = flag_q;
   assign irq_o  = irq_q;

endmodule

// File: rtl/chg_irq_det.sv
module chg_irq_det #(
   parameter int unsigned NPINS       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [NPINS-1:0] pin_i,
   input  logic [NPINS-1:0] dir_in_i,
   input  logic             rd_strobe_i,
   input  logic             irq_en_i,
   input  logic             flag_clr_i,
   output logic             chg_flag_o,
   output logic             irq_o
);

   generate
      if (NPINS < 1 || NPINS > chgdet_pkg::MAX_PINS) begin : g_bad_npins
         $error("chg_irq_det: NPINS out of range");
      end
      if (SYNC_STAGES > chgdet_pkg::MAX_SYNC) begin : g_bad_sync
         $error("chg_irq_det: SYNC_STAGES out of range");
      end
   endgenerate

   chgdet_pkg::strobe_edge_t rd_edge;
   logic             rd_rise;
   logic             rd_fall;
   logic [NPINS-1:0] cur_lat;
   logic [NPINS-1:0] prev_lat;
   logic             mis_any;

   chgdet_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i    (clk_i),
      .rst_n_i  (rst_n_i),
      .strobe_i (rd_strobe_i),
      .edge_o   (rd_edge)
   );

   assign rd_rise = rd_edge.rise;
   assign rd_fall = rd_edge.fall;

   chgdet_latch_pair #(.NPINS(NPINS)) u_lat (
      .clk_i       (clk_i),
      .rst_n_i     (rst_n_i),
      .pin_i       (pin_i),
      .dir_in_i    (dir_in_i),
      .load_cur_i  (rd_rise),
      .load_prev_i (rd_fall),
      .cur_o       (cur_lat),
      .prev_o      (prev_lat),
      .mis_o       (mis_any)
   );

   chgdet_flag u_flag (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .set_i   (mis_any),
      .clr_i   (flag_clr_i),
      .en_i    (irq_en_i),
      .flag_o  (chg_flag_o),
      .irq_o   (irq_o)
   );

endmodule

// File: rtl/chg_irq_det_chk.sv
module chg_irq_det_chk #(
   parameter int unsigned NPINS = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPINS-1:0] pins,
   input logic [NPINS-1:0] dir,
   input logic             rise,
   input logic             fall,
   input logic [NPINS-1:0] cur,
   input logic [NPINS-1:0] prev,
   input logic             mis,
   input logic             clr,
   input logic             en,
   input logic             flag,
   input logic             irq
);

   p_edges_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise && fall));

   p_cur_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> cur == $past(pins));

   p_cur_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> $stable(cur));

   p_prev_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> prev == $past(pins));

   p_mis_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mis |=> flag);

   p_outputs_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mis |-> (((cur ^ prev) & dir) != '0));

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !mis) |=> !flag);

   p_clr_loses_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && mis) |=> flag);

   p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq == ($past(flag) && $past(en)));

endmodule

bind chg_irq_det chg_irq_det_chk #(.NPINS(NPINS)) u_chk (
   .clk   (clk_i),
   .rst_n (rst_n_i),
   .pins  (pin_i),
   .dir   (dir_in_i),
   .rise  (rd_rise),
   .fall  (rd_fall),
   .cur   (cur_lat),
   .prev  (prev_lat),
   .mis   (mis_any),
   .clr   (flag_clr_i),
   .en    (irq_en_i),
   .flag  (chg_flag_o),
   .irq   (irq_o)
);

// File: tb/chg_irq_det_test.sv
module chg_irq_det_test;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 4;
   localparam int SYNC       = 2;
   localparam int RAND_CYC   = 4000;
   localparam int WDOG_CYC   = 150000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pins = '0;
   logic [N-1:0] dir = '1;
   logic         rd = 1'b0;
   logic         en = 1'b0;
   logic         clr = 1'b0;
   logic         flag;
   logic         irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   chg_irq_det #(.NPINS(N), .SYNC_STAGES(SYNC)) uut (
      .clk_i       (clk),
      .rst_n_i     (rst_n),
      .pin_i       (pins),
      .dir_in_i    (dir),
      .rd_strobe_i (rd),
      .irq_en_i    (en),
      .flag_clr_i  (clr),
      .chg_flag_o  (flag),
      .irq_o       (irq)
   );

   // reference model built from the requirements
   logic [SYNC-1:0] m_sync;
   logic            m_lvl_prev;
   logic [N-1:0]    m_cur, m_prev;
   logic            m_flag, m_irq;

   function automatic logic mis_of(logic [N-1:0] c, logic [N-1:0] p, logic [N-1:0] d);
      return |((c ^ p) & d);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sync <= '0; m_lvl_prev <= 1'b0; m_cur <= '0; m_prev <= '0;
         m_flag <= 1'b0; m_irq <= 1'b0;
      end else begin
         m_sync     <= {m_sync[SYNC-2:0], rd};
         m_lvl_prev <= m_sync[SYNC-1];
         if (m_sync[SYNC-1] && !m_lvl_prev) m_cur  <= pins;
         if (!m_sync[SYNC-1] && m_lvl_prev) m_prev <= pins;
         if (mis_of(m_cur, m_prev, dir)) m_flag <= 1'b1;
         else if (clr)                   m_flag <= 1'b0;
         m_irq <= m_flag & en;
      end
   end

   task automatic check(input string tag, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic read_stable();
      rd = 1'b1; wait_cyc(6);
      rd = 1'b0; wait_cyc(6);
   endtask

   task automatic read_with_change(input logic [N-1:0] newval);
      rd = 1'b1; wait_cyc(6);
      pins = newval; wait_cyc(2);
      rd = 1'b0; wait_cyc(6);
   endtask

   task automatic pulse_clr();
      clr = 1'b1; wait_cyc(1);
      clr = 1'b0;
   endtask

   initial begin : watchdog
      repeat (WDOG_CYC) @(posedge clk);
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual expired expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      wait_cyc(3);
      // R1: reset values
      check("R1 flag in reset", flag, 1'b0);
      check("R1 irq in reset", irq, 1'b0);
      rst_n = 1'b1;
      wait_cyc(4);
      check("R1 flag after reset, pins 0", flag, 1'b0);

      // R10: read with stable pins
      read_stable();
      check("R10 stable read leaves flag clear", flag, 1'b0);

      // R2: pins move without a read
      pins = 4'h5; wait_cyc(5);
      check("R2 no sampling without read strobe", flag, 1'b0);

      // R4: read loads current latch first, previous latch later -> mismatch window
      rd = 1'b1; wait_cyc(5);
      check("R4 flag set after current latch loads", flag, 1'b1);
      rd = 1'b0; wait_cyc(6);
      // R7: sticky
      check("R7 flag sticky after latches agree", flag, 1'b1);
      pulse_clr();
      check("R7 clear with no mismatch", flag, 1'b0);
      wait_cyc(3);
      check("R3 previous latch caught up, no re-set", flag, 1'b0);

      // R6: change during read
      read_with_change(4'hA);
      check("R6 change while strobe high sets flag", flag, 1'b1);
      pulse_clr();
      // R8: clear loses to a standing mismatch
      check("R8 clear ignored while mismatch stands", flag, 1'b1);
      wait_cyc(3);
      check("R8 flag still set", flag, 1'b1);
      read_stable();
      pulse_clr();
      check("R8 clear after re-aligning read", flag, 1'b0);

      // R5: only output-mode pins change during read
      dir = 4'b0011;
      read_with_change(4'b0110);
      check("R5 output-mode pins ignored", flag, 1'b0);
      read_stable();
      dir = 4'b1111;
      wait_cyc(2);
      check("R5 latches aligned after read", flag, 1'b0);

      // R9: interrupt gating
      en = 1'b1;
      read_with_change(4'b1001);
      wait_cyc(1);
      check("R9 irq with flag and enable", irq, 1'b1);
      en = 1'b0; wait_cyc(2);
      check("R9 irq masked by enable", irq, 1'b0);
      check("R9 flag kept while masked", flag, 1'b1);
      read_stable();
      pulse_clr();
      check("R7 flag cleared before random phase", flag, 1'b0);

      // random phase against the model (R2 R3 R4 R7 R8 R9)
      void'($urandom(32'h1F2E3D4C));
      begin
         int hold = 0;
         for (int c = 0; c < RAND_CYC; c++) begin
            @(negedge clk);
            check("R4 model flag", flag, m_flag);
            check("R9 model irq", irq, m_irq);
            if (hold == 0) begin
               rd = ~rd;
               hold = 1 + ($urandom % 9);
            end else begin
               hold--;
            end
            if (($urandom % 6) == 0) pins = N'($urandom);
            if (($urandom % 40) == 0) dir = N'($urandom);
            clr = (($urandom % 5) == 0);
            en  = (($urandom % 3) != 0);
         end
      end

      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule